// File: doc/BRIEF.md
# Dual-Bank Glitchless Clock Configuration Controller

This block keeps two complete divider configurations for one clock output. Each configuration, called a bank, holds a source-select code, a pre-divider setting, an M/N counter pair, an M/N enable, a 2-bit M/N mode and an M/N counter-reset bit. One select bit in a bank-control register names the live bank. Software programs the banks through a simple synchronous write port. It can read any register back on a combinational read port.

The controller drives a registered snapshot of the live configuration to the downstream divider and source mux. When the clock output is enabled, the snapshot changes only in the cycle after the downstream divider reports a period boundary on `div_wrap`. Software can therefore fill the idle bank, flip the select bit, and have the whole new setting take effect at one clean edge. When the output is disabled, the snapshot follows the selected bank every cycle, so software simply rewrites the live bank in place.

A bank whose counter-reset bit is set is never loaded into the snapshot. Software sets that bit first, writes M, N and mode, and clears it last. This guarantees that a half-programmed bank is never exposed. A parameter chooses where the M/N enable and mode come from: either each bank's own configuration word or one shared copy in the bank-control register.

Top module: `dyncfg_ctrl`

## Requirements
- R1: Writes with `wr_en` high land on the next clock edge. The register addresses are:
  - 0: bank control, with bit 0 the bank select, bit 1 the shared M/N enable and bits 3:2 the shared M/N mode.
  - 1: bank 0 configuration word.
  - 2: bank 0 M value.
  - 3: bank 1 configuration word.
  - 4: bank 1 M value.
  Writes to any other address change nothing. `rd_data` returns the stored bits of the addressed register and zero for unused addresses.
- R2: `act_bank` reports the bank whose settings are in the snapshot. After a load it equals the select bit.
- R3: While `out_en` is 1, the snapshot loads only on a clock edge where `div_wrap` is 1. Writes to either bank and to the select bit leave the outputs unchanged until then.
- R4: While `out_en` is 0, the snapshot loads from the selected bank on every edge. A write therefore shows on the outputs two edges after it is presented.
- R5: While the counter-reset bit (configuration bit 15 by default) of the selected bank is 1, the snapshot does not load, whatever `out_en` and `div_wrap` are. It resumes once the bit is cleared.
- R6: The source field is 3 bits at the configurable offset, default bits 2:0. Its codes map to parent indices 1→0, 2→1, 5→2 and 6→3. Any other code gives index 0.
- R7: The pre-divider field, bits 6:3 by default, holds the division ratio minus one. `act_ratio` is that field plus one, covering 1 to 16.
- R8: The configuration word's N field, bits 14:7 by default, holds the bitwise inverse of N−M. `act_n` is the inverse of that field plus M, modulo 2^8. `act_m` is the low 8 bits of the bank's M register.
- R9: With per-bank mode control, `act_mn_en` and `act_mn_mode` come from configuration bits 16 and 18:17. With shared mode control, they come from bank-control bits 1 and 3:2, and the per-bank bits are ignored.
- R10: During reset, the select bit and all stored registers are 0. The outputs show bank 0, source index 0, ratio 1, M 0, N 0, with the M/N enable off and mode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W (3) | Register write address |
| wr_data | input | DATA_W (32) | Register write data |
| rd_addr | input | ADDR_W (3) | Register read address |
| rd_data | output | DATA_W (32) | Register read data, combinational |
| out_en | input | 1 | Clock output is running |
| div_wrap | input | 1 | Downstream divider period boundary, one cycle |
| act_bank | output | 1 | Bank in the live snapshot |
| act_src_idx | output | IDX_W (2) | Live parent index |
| act_ratio | output | PD_W+1 (5) | Live pre-division ratio |
| act_m | output | MN_W (8) | Live M value |
| act_n | output | MN_W (8) | Live N value |
| act_mn_en | output | 1 | Live M/N counter enable |
| act_mn_mode | output | 2 | Live M/N counter mode |

## Verification
The interesting collisions are a boundary pulse landing in the same cycle as a register write, and a boundary pulse while the target bank is still held in counter reset. The bench provokes the first by writing the live bank while the output is enabled. It judges that the new value appears only after the next `div_wrap`, and that idle-bank and select writes stay invisible until then. It provokes the second by flipping the select bit to a bank whose reset bit is set and then pulsing `div_wrap`. The bank number and ratio must stay on the old bank, and they must change only on the first boundary after the reset bit is cleared.

// File: rtl/dyncfg_pkg.sv
package dyncfg_pkg;

   typedef enum logic [2:0] {
      ADR_CTRL   = 3'd0,
      ADR_B0_CFG = 3'd1,
      ADR_B0_M   = 3'd2,
      ADR_B1_CFG = 3'd3,
      ADR_B1_M   = 3'd4
   } dyncfg_addr_e;

   localparam int CTRL_W        = 4;
   localparam int CTRL_SEL_BIT  = 0;
   localparam int CTRL_EN_BIT   = 1;
   localparam int CTRL_MODE_LSB = 2;
   localparam int MODE_W        = 2;
   localparam int NUM_BANKS     = 2;
   localparam int CFG_TAIL_W    = 2 + MODE_W;

endpackage

// File: rtl/dyncfg_regfile.sv
module dyncfg_regfile
   import dyncfg_pkg::*;
#(
   parameter int ADDR_W = 3,
   parameter int DATA_W = 32,
   parameter int CFG_W  = 19,
   parameter int MN_W   = 8
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            wr_en,
   input  logic [ADDR_W-1:0]               wr_addr,
   input  logic [DATA_W-1:0]               wr_data,
   input  logic [ADDR_W-1:0]               rd_addr,
   output logic [DATA_W-1:0]               rd_data,
   output logic [CTRL_W-1:0]               ctrl_q,
   output logic [NUM_BANKS-1:0][CFG_W-1:0] cfg_q,
   output logic [NUM_BANKS-1:0][MN_W-1:0]  m_q
);

   localparam int CFG_PAD = DATA_W - CFG_W;
   localparam int M_PAD   = DATA_W - MN_W;
   localparam int C_PAD   = DATA_W - CTRL_W;

   if (ADDR_W < 3) begin : g_bad_addr
      $error("dyncfg_regfile: ADDR_W must be at least 3");
   end
   if (CFG_W > DATA_W || MN_W > DATA_W) begin : g_bad_width
      $error("dyncfg_regfile: register wider than data bus");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (wr_en && wr_addr == ADDR_W'(ADR_CTRL)) begin
         ctrl_q <= wr_data[CTRL_W-1:0];
      end
   end

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      localparam logic [ADDR_W-1:0] CFG_ADR = ADDR_W'(1 + 2 * b);
      localparam logic [ADDR_W-1:0] M_ADR   = ADDR_W'(2 + 2 * b);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cfg_q[b] <= '0;
            m_q[b]   <= '0;
         end else if (wr_en) begin
            if (wr_addr == CFG_ADR) cfg_q[b] <= wr_data[CFG_W-1:0];
            if (wr_addr == M_ADR)   m_q[b]   <= wr_data[MN_W-1:0];
         end
      end
   end

   always_comb begin
      rd_data = '0;
      case (rd_addr)
         ADDR_W'(ADR_CTRL):   rd_data = {{C_PAD{1'b0}}, ctrl_q};
         ADDR_W'(ADR_B0_CFG): rd_data = {{CFG_PAD{1'b0}}, cfg_q[0]};
         ADDR_W'(ADR_B0_M):   rd_data = {{M_PAD{1'b0}}, m_q[0]};
         ADDR_W'(ADR_B1_CFG): rd_data = {{CFG_PAD{1'b0}}, cfg_q[1]};
         ADDR_W'(ADR_B1_M):   rd_data = {{M_PAD{1'b0}}, m_q[1]};
         default:             rd_data = '0;
      endcase
   end

endmodule

// File: rtl/dyncfg_decode.sv
module dyncfg_decode
   import dyncfg_pkg::*;
#(
   parameter int SRC_LSB     = 0,
   parameter int SRC_W       = 3,
   parameter int PD_W        = 4,
   parameter int MN_W        = 8,
   parameter int NUM_PARENTS = 4,
   parameter logic [NUM_PARENTS-1:0][SRC_W-1:0] PARENT_CODES = '0,
   parameter bit SHARED_MODE = 1'b0,
   parameter int CFG_W       = SRC_LSB + SRC_W + PD_W + MN_W + CFG_TAIL_W,
   parameter int IDX_W       = (NUM_PARENTS > 1) ? $clog2(NUM_PARENTS) : 1
) (
   input  logic [CFG_W-1:0]  cfg,
   input  logic [MN_W-1:0]   m_in,
   input  logic              sh_en,
   input  logic [MODE_W-1:0] sh_mode,
   output logic [IDX_W-1:0]  src_idx,
   output logic [PD_W:0]     ratio,
   output logic [MN_W-1:0]   m_val,
   output logic [MN_W-1:0]   n_val,
   output logic              mn_en,
   output logic [MODE_W-1:0] mn_mode,
   output logic              ctr_rst
);

   localparam int PD_LSB   = SRC_LSB + SRC_W;
   localparam int N_LSB    = PD_LSB + PD_W;
   localparam int RST_BIT  = N_LSB + MN_W;
   localparam int EN_BIT   = RST_BIT + 1;
   localparam int MODE_LSB = RST_BIT + 2;

   logic [SRC_W-1:0] src_code;
   logic [PD_W-1:0]  pd_field;
   logic [MN_W-1:0]  n_field;

   assign src_code = cfg[PD_LSB-1:SRC_LSB];
   assign pd_field = cfg[N_LSB-1:PD_LSB];
   assign n_field  = cfg[RST_BIT-1:N_LSB];
   assign ctr_rst  = cfg[RST_BIT];

   always_comb begin
      logic hit;
      hit     = 1'b0;
      src_idx = '0;
      for (int i = 0; i < NUM_PARENTS; i++) begin
         if (!hit && src_code == PARENT_CODES[i]) begin
            hit     = 1'b1;
            src_idx = IDX_W'(i);
         end
      end
   end

   assign ratio = {1'b0, pd_field} + {{PD_W{1'b0}}, 1'b1};
   assign m_val = m_in;
   assign n_val = (~n_field) + m_in;

   if (SHARED_MODE) begin : g_shared
      assign mn_en   = sh_en;
      assign mn_mode = sh_mode;
   end else begin : g_banked
      assign mn_en   = cfg[EN_BIT];
      assign mn_mode = cfg[MODE_LSB+MODE_W-1:MODE_LSB];
   end

endmodule

// File: rtl/dyncfg_switch.sv
module dyncfg_switch
   import dyncfg_pkg::*;
#(
   parameter int PD_W  = 4,
   parameter int MN_W  = 8,
   parameter int IDX_W = 2
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              out_en,
   input  logic                              div_wrap,
   input  logic                              sel,
   input  logic [NUM_BANKS-1:0][IDX_W-1:0]   b_src,
   input  logic [NUM_BANKS-1:0][PD_W:0]      b_ratio,
   input  logic [NUM_BANKS-1:0][MN_W-1:0]    b_m,
   input  logic [NUM_BANKS-1:0][MN_W-1:0]    b_n,
   input  logic [NUM_BANKS-1:0]              b_en,
   input  logic [NUM_BANKS-1:0][MODE_W-1:0]  b_mode,
   input  logic [NUM_BANKS-1:0]              b_rst,
   output logic                              act_bank,
   output logic [IDX_W-1:0]                  act_src_idx,
   output logic [PD_W:0]                     act_ratio,
   output logic [MN_W-1:0]                   act_m,
   output logic [MN_W-1:0]                   act_n,
   output logic                              act_mn_en,
   output logic [MODE_W-1:0]                 act_mn_mode
);

   logic at_edge;
   logic load;

   assign at_edge = !out_en || div_wrap;
   assign load    = at_edge && !b_rst[sel];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_bank    <= 1'b0;
         act_src_idx <= '0;
         act_ratio   <= (PD_W+1)'(1);
         act_m       <= '0;
         act_n       <= '0;
         act_mn_en   <= 1'b0;
         act_mn_mode <= '0;
      end else if (load) begin
         act_bank    <= sel;
         act_src_idx <= b_src[sel];
         act_ratio   <= b_ratio[sel];
         act_m       <= b_m[sel];
         act_n       <= b_n[sel];
         act_mn_en   <= b_en[sel];
         act_mn_mode <= b_mode[sel];
      end
   end

endmodule

// File: rtl/dyncfg_ctrl.sv
module dyncfg_ctrl
   import dyncfg_pkg::*;
#(
   parameter int ADDR_W      = 3,
   parameter int DATA_W      = 32,
   parameter int SRC_LSB     = 0,
   parameter int SRC_W       = 3,
   parameter int PD_W        = 4,
   parameter int MN_W        = 8,
   parameter int NUM_PARENTS = 4,
   parameter logic [NUM_PARENTS-1:0][SRC_W-1:0] PARENT_CODES = {3'd6, 3'd5, 3'd2, 3'd1},
   parameter bit SHARED_MODE = 1'b0,
   localparam int IDX_W      = (NUM_PARENTS > 1) ? $clog2(NUM_PARENTS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   input  logic              out_en,
   input  logic              div_wrap,
   output logic              act_bank,
   output logic [IDX_W-1:0]  act_src_idx,
   output logic [PD_W:0]     act_ratio,
   output logic [MN_W-1:0]   act_m,
   output logic [MN_W-1:0]   act_n,
   output logic              act_mn_en,
   output logic [1:0]        act_mn_mode
);

   localparam int CFG_W = SRC_LSB + SRC_W + PD_W + MN_W + CFG_TAIL_W;

   if (CFG_W > DATA_W) begin : g_bad_cfg
      $error("dyncfg_ctrl: configuration word does not fit the data bus");
   end
   if (NUM_PARENTS < 1 || NUM_PARENTS > (1 << SRC_W)) begin : g_bad_par
      $error("dyncfg_ctrl: NUM_PARENTS out of range for SRC_W");
   end
   if (PD_W < 1 || MN_W < 1) begin : g_bad_fld
      $error("dyncfg_ctrl: field widths must be positive");
   end

   logic [CTRL_W-1:0]                ctrl_q;
   logic [NUM_BANKS-1:0][CFG_W-1:0]  cfg_q;
   logic [NUM_BANKS-1:0][MN_W-1:0]   m_q;
   logic [NUM_BANKS-1:0][IDX_W-1:0]  b_src;
   logic [NUM_BANKS-1:0][PD_W:0]     b_ratio;
   logic [NUM_BANKS-1:0][MN_W-1:0]   b_m;
   logic [NUM_BANKS-1:0][MN_W-1:0]   b_n;
   logic [NUM_BANKS-1:0]             b_en;
   logic [NUM_BANKS-1:0][MODE_W-1:0] b_mode;
   logic [NUM_BANKS-1:0]             b_rst;
   logic                             sel_q;
   logic                             tgt_rst;

   assign sel_q   = ctrl_q[CTRL_SEL_BIT];
   assign tgt_rst = b_rst[sel_q];

   dyncfg_regfile #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .CFG_W  (CFG_W),
      .MN_W   (MN_W)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rd_addr (rd_addr),
      .rd_data (rd_data),
      .ctrl_q  (ctrl_q),
      .cfg_q   (cfg_q),
      .m_q     (m_q)
   );

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_dec
      dyncfg_decode #(
         .SRC_LSB      (SRC_LSB),
         .SRC_W        (SRC_W),
         .PD_W         (PD_W),
         .MN_W         (MN_W),
         .NUM_PARENTS  (NUM_PARENTS),
         .PARENT_CODES (PARENT_CODES),
         .SHARED_MODE  (SHARED_MODE),
         .CFG_W        (CFG_W),
         .IDX_W        (IDX_W)
      ) u_dec (
         .cfg     (cfg_q[b]),
         .m_in    (m_q[b]),
         .sh_en   (ctrl_q[CTRL_EN_BIT]),
         .sh_mode (ctrl_q[CTRL_MODE_LSB+MODE_W-1:CTRL_MODE_LSB]),
         .src_idx (b_src[b]),
         .ratio   (b_ratio[b]),
         .m_val   (b_m[b]),
         .n_val   (b_n[b]),
         .mn_en   (b_en[b]),
         .mn_mode (b_mode[b]),
         .ctr_rst (b_rst[b])
      );
   end

   dyncfg_switch #(
      .PD_W  (PD_W),
      .MN_W  (MN_W),
      .IDX_W (IDX_W)
   ) u_switch (
      .clk         (clk),
      .rst_n       (rst_n),
      .out_en      (out_en),
      .div_wrap    (div_wrap),
      .sel         (sel_q),
      .b_src       (b_src),
      .b_ratio     (b_ratio),
      .b_m         (b_m),
      .b_n         (b_n),
      .b_en        (b_en),
      .b_mode      (b_mode),
      .b_rst       (b_rst),
      .act_bank    (act_bank),
      .act_src_idx (act_src_idx),
      .act_ratio   (act_ratio),
      .act_m       (act_m),
      .act_n       (act_n),
      .act_mn_en   (act_mn_en),
      .act_mn_mode (act_mn_mode)
   );

endmodule

// File: rtl/dyncfg_ctrl_chk.sv
module dyncfg_ctrl_chk #(
   parameter int PD_W = 4,
   parameter int MN_W = 8
) (
   input logic            clk,
   input logic            rst_n,
   input logic            out_en,
   input logic            div_wrap,
   input logic            sel_q,
   input logic            tgt_rst,
   input logic            act_bank,
   input logic [PD_W:0]   act_ratio,
   input logic [MN_W-1:0] act_n
);

   AST_HOLD_OFF_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
      (out_en && !div_wrap) |=> ($stable(act_bank) && $stable(act_ratio) && $stable(act_n))); // R3

   AST_RESET_BIT_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
      tgt_rst |=> ($stable(act_bank) && $stable(act_ratio) && $stable(act_n))); // R5

   AST_DISABLED_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      (!out_en && !tgt_rst) |=> (act_bank == $past(sel_q))); // R4

   AST_SWAP_ONLY_AT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(act_bank) |-> ($past(div_wrap) || !$past(out_en))); // R2

endmodule

bind dyncfg_ctrl dyncfg_ctrl_chk #(
   .PD_W (PD_W),
   .MN_W (MN_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .out_en    (out_en),
   .div_wrap  (div_wrap),
   .sel_q     (sel_q),
   .tgt_rst   (tgt_rst),
   .act_bank  (act_bank),
   .act_ratio (act_ratio),
   .act_n     (act_n)
);

// File: tb/dyncfg_ctrl_tb.sv
`timescale 1ns/1ps
module dyncfg_ctrl_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [2:0]  rd_addr = '0;
   logic        out_en = 1'b0;
   logic        div_wrap = 1'b0;

   logic [31:0] rd_data, rd_data_s;
   logic        act_bank, act_bank_s;
   logic [1:0]  act_src_idx, act_src_idx_s;
   logic [4:0]  act_ratio, act_ratio_s;
   logic [7:0]  act_m, act_m_s, act_n, act_n_s;
   logic        act_mn_en, act_mn_en_s;
   logic [1:0]  act_mn_mode, act_mn_mode_s;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   dyncfg_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .out_en(out_en), .div_wrap(div_wrap),
      .act_bank(act_bank), .act_src_idx(act_src_idx), .act_ratio(act_ratio),
      .act_m(act_m), .act_n(act_n), .act_mn_en(act_mn_en), .act_mn_mode(act_mn_mode)
   );

   dyncfg_ctrl #(.SHARED_MODE(1'b1)) u_dut_sh (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data_s), .out_en(out_en), .div_wrap(div_wrap),
      .act_bank(act_bank_s), .act_src_idx(act_src_idx_s), .act_ratio(act_ratio_s),
      .act_m(act_m_s), .act_n(act_n_s), .act_mn_en(act_mn_en_s), .act_mn_mode(act_mn_mode_s)
   );

   typedef struct packed {
      logic [2:0] code;
      logic [3:0] pd;
      logic [7:0] m;
      logic [7:0] n;
      logic       en;
      logic [1:0] mode;
      logic [1:0] idx;
   } vec_t;

   localparam int NVEC = 6;
   localparam vec_t VECS [NVEC] = '{
      '{3'd1, 4'd0,  8'd1,   8'd3,   1'b1, 2'd2, 2'd0},
      '{3'd2, 4'd3,  8'd3,   8'd16,  1'b0, 2'd0, 2'd1},
      '{3'd5, 4'd15, 8'd1,   8'd2,   1'b1, 2'd1, 2'd2},
      '{3'd6, 4'd7,  8'd0,   8'd0,   1'b0, 2'd3, 2'd3},
      '{3'd3, 4'd5,  8'd4,   8'd255, 1'b1, 2'd2, 2'd0},
      '{3'd0, 4'd1,  8'd200, 8'd201, 1'b0, 2'd0, 2'd0}
   };

   function automatic logic [31:0] mk_cfg(input logic [2:0] code, input logic [3:0] pd,
                                          input logic [7:0] m, input logic [7:0] n,
                                          input logic rst, input logic en, input logic [1:0] mode);
      logic [7:0] nf;
      nf = ~(n - m);
      return {13'd0, mode, en, rst, nf, pd, code};
   endfunction

   task automatic check(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0; wr_addr = '0; wr_data = '0;
   endtask

   task automatic boundary();
      div_wrap = 1'b1;
      @(negedge clk);
      div_wrap = 1'b0;
   endtask

   initial begin
      repeat (4000) @(negedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired before the sequence ended");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      // R10: state during reset
      repeat (3) @(negedge clk);
      check("R10", "bank", act_bank, 0);
      check("R10", "src", act_src_idx, 0);
      check("R10", "ratio", act_ratio, 1);
      check("R10", "m", act_m, 0);
      check("R10", "n", act_n, 0);
      check("R10", "en", act_mn_en, 0);
      check("R10", "mode", act_mn_mode, 0);
      rd_addr = 3'd1;
      #1 check("R10", "readback cfg0", rd_data, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // Vector table, output disabled, bank 0 live
      for (int i = 0; i < NVEC; i++) begin
         wr(3'd1, mk_cfg(VECS[i].code, VECS[i].pd, VECS[i].m, VECS[i].n, 1'b0, VECS[i].en, VECS[i].mode));
         wr(3'd2, {24'd0, VECS[i].m});
         @(negedge clk);
         check("R6", "src idx", act_src_idx, VECS[i].idx);
         check("R7", "ratio", act_ratio, {1'b0, VECS[i].pd} + 5'd1);
         check("R8", "m", act_m, VECS[i].m);
         check("R8", "n", act_n, VECS[i].n);
         check("R9", "per-bank en", act_mn_en, VECS[i].en);
         check("R9", "per-bank mode", act_mn_mode, VECS[i].mode);
         rd_addr = 3'd1;
         #1 check("R1", "readback cfg0",
                  rd_data, mk_cfg(VECS[i].code, VECS[i].pd, VECS[i].m, VECS[i].n, 1'b0, VECS[i].en, VECS[i].mode));
      end
      // last vector live: code 0 -> idx 0, ratio 2, m 200, n 201

      // R1: unused address ignored
      wr(3'd6, 32'hFFFF_FFFF);
      @(negedge clk);
      rd_addr = 3'd6;
      #1 check("R1", "unused readback", rd_data, 0);
      rd_addr = 3'd0;
      #1 check("R1", "ctrl untouched", rd_data, 0);
      check("R1", "ratio untouched", act_ratio, 2);

      // R3: program idle bank 1 while running; nothing moves before a boundary
      out_en = 1'b1;
      wr(3'd3, mk_cfg(3'd2, 4'd2, 8'd1, 8'd4, 1'b0, 1'b1, 2'd2));
      wr(3'd4, 32'd1);
      wr(3'd0, 32'd1);
      repeat (3) @(negedge clk);
      check("R3", "bank before boundary", act_bank, 0);
      check("R3", "ratio before boundary", act_ratio, 2);
      boundary();
      check("R2", "bank after boundary", act_bank, 1);
      check("R3", "ratio after boundary", act_ratio, 3);
      check("R6", "src after swap", act_src_idx, 1);
      check("R8", "n after swap", act_n, 4);

      // R3: live bank write while running waits for boundary
      wr(3'd3, mk_cfg(3'd2, 4'd5, 8'd1, 8'd4, 1'b0, 1'b1, 2'd2));
      repeat (2) @(negedge clk);
      check("R3", "live write held", act_ratio, 3);
      boundary();
      check("R3", "live write at boundary", act_ratio, 6);

      // R5: swap toward a bank held in counter reset is refused
      wr(3'd1, mk_cfg(3'd5, 4'd1, 8'd2, 8'd9, 1'b1, 1'b0, 2'd0));
      wr(3'd0, 32'd0);
      boundary();
      check("R5", "bank held in reset", act_bank, 1);
      check("R5", "ratio held in reset", act_ratio, 6);
      wr(3'd2, 32'd2);
      boundary();
      check("R5", "still held", act_bank, 1);
      wr(3'd1, mk_cfg(3'd5, 4'd1, 8'd2, 8'd9, 1'b0, 1'b0, 2'd0));
      @(negedge clk);
      check("R5", "no swap before boundary", act_bank, 1);
      boundary();
      check("R5", "bank after release", act_bank, 0);
      check("R5", "ratio after release", act_ratio, 2);
      check("R6", "src after release", act_src_idx, 2);
      check("R8", "n after release", act_n, 9);

      // R4: disabled output follows in place
      out_en = 1'b0;
      wr(3'd1, mk_cfg(3'd5, 4'd9, 8'd2, 8'd9, 1'b0, 1'b0, 2'd0));
      @(negedge clk);
      check("R4", "in-place ratio", act_ratio, 10);
      wr(3'd0, 32'd1);
      @(negedge clk);
      check("R4", "disabled select", act_bank, 1);
      check("R2", "bank1 ratio", act_ratio, 6);

      // R9: shared vs per-bank mode control
      wr(3'd0, 32'hF);
      @(negedge clk);
      check("R9", "per-bank en", act_mn_en, 1);
      check("R9", "per-bank mode", act_mn_mode, 2);
      check("R9", "shared en", act_mn_en_s, 1);
      check("R9", "shared mode", act_mn_mode_s, 3);
      wr(3'd0, 32'h1);
      @(negedge clk);
      check("R9", "per-bank mode kept", act_mn_mode, 2);
      check("R9", "shared en off", act_mn_en_s, 0);
      check("R9", "shared mode 0", act_mn_mode_s, 0);
      check("R2", "shared bank", act_bank_s, 1);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule